// File: doc/BRIEF.md
# Edge-Interrupt GPIO Register Controller

This block is an eight-line general-purpose I/O peripheral reached through a byte-wide register port. The low four lines are driven outputs and the high four lines are monitored inputs that can raise an interrupt. Software programs a direction byte and an output byte, reads the synchronised pin levels back through the data register, and chooses one edge per input for the interrupt status.

Every monitored input keeps two pending flags, one for rising edges and one for falling edges. Both flags latch on every edge the input makes. The trigger configuration only decides which of the two flags shows in the status register and drives the interrupt line. A write of one to a status bit wipes both flags of that input. Software can therefore get both-edge behaviour by clearing the status and then selecting the opposite edge after each interrupt.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: The register at offset 0 holds the direction byte (1 = output, 0 = input). It is written by a write strobe, read back unchanged and driven on `dir_o` from the cycle after the write.
- R2: A write to offset 1 sets `out_o` from the next cycle. A read of offset 1 returns the pin levels after a two-flop synchroniser, so a pin change is visible two clock edges after the edge at which it is first sampled. The written output value is never read back.
- R3: The register at offset 3 holds the trigger configuration and reads back as written. Input i (line 4+i) uses bits 2i+1:2i. Code 00 shows nothing, 01 shows the falling flag and 10 shows the rising flag.
- R4: The trigger code 11 shows nothing, the same as 00.
- R5: Each input line 4 to 7 latches a rising flag and a falling flag on every edge, whatever its configuration. The flag is set on the third clock edge after the pin change is first sampled. Lines 0 to 3 never set a flag.
- R6: A read of offset 4 returns in bit i the flag selected for input i, and zero in bits 7:4.
- R7: A write to offset 4 clears both flags of every input whose bit is 1. Inputs whose bit is 0 are left alone.
- R8: When a clear write and a new edge on the same input meet at the same clock edge, the flag of the new edge stays set.
- R9: `irq_o` is high exactly when some status bit read at offset 4 would be one.
- R10: Reads of offsets 2, 5, 6 and 7 return zero, and writes to those offsets change no register.
- R11: Reset, synchronous and active low, clears direction, output, configuration and all flags, so all outputs start low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 3 | Register offset for read and write |
| wr_en_i | input | 1 | Write strobe, taken at the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| pins_i | input | 8 | Sampled pin levels of all eight lines |
| dir_o | output | 8 | Direction byte, 1 = output |
| out_o | output | 8 | Output value byte |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
Register writes are due on the outputs and on read-back one clock edge after the strobe, pin levels on the data read two edges after first sampling, and a pending flag with its interrupt three edges after first sampling. A status clear acts at its own edge, so it meets a new edge exactly when the write lands on the third edge after that pin change. The bench drives every input on the falling clock edge and steps a cycle model of the register file, synchroniser and flags at each rising edge. It then compares read data, interrupt, direction and output half a period later, so every result is checked in the cycle it is due. Directed sequences place the clear and the edge on the same edge and step through all four trigger codes on flags that are already latched.

// File: rtl/edge_gpio_ctrl_pkg.sv
// Shared constants and types for the edge-interrupt GPIO controller.
// Assumes a byte-wide register port with a fixed offset map.
package edge_gpio_ctrl_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] OFF_DIR  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_TRIG = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;

    // Per-input trigger selection code
    typedef enum logic [1:0] {
        TRIG_NONE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_RSVD = 2'b11
    } trig_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage level synchroniser for asynchronous pin inputs.
// Assumes STAGES >= 1; all stages reset to zero.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage retimes the one before
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
// Edge detector and pending-flag store for the interrupt-capable inputs.
// Each input keeps separate rising and falling flags that latch on every
// edge; the trigger code picks which flag is visible. A clear wipes both
// flags, but an edge arriving in the same cycle keeps its flag set.
// Assumes lvl_i is already synchronised to clk.
module gpio_edge_flags
    import edge_gpio_ctrl_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IN-1:0]     lvl_i,
    input  logic [2*NUM_IN-1:0]   cfg_i,
    input  logic [NUM_IN-1:0]     clr_i,
    output logic [NUM_IN-1:0]     vis_o
);
    genvar i;
    generate
        for (i = 0; i < NUM_IN; i++) begin : g_in
            logic  prev_q;
            logic  rise_flag_q;
            logic  fall_flag_q;
            logic  rise_det;
            logic  fall_det;
            trig_e code;

            assign rise_det = lvl_i[i] & ~prev_q;
            assign fall_det = ~lvl_i[i] & prev_q;
            assign code     = trig_e'(cfg_i[2*i +: 2]);

            // Remember the previous synchronised level
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= lvl_i[i];
            end

            // Latch both flags; a new edge overrides a same-cycle clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rise_flag_q <= 1'b0;
                    fall_flag_q <= 1'b0;
                end else begin
                    rise_flag_q <= rise_det | (rise_flag_q & ~clr_i[i]);
                    fall_flag_q <= fall_det | (fall_flag_q & ~clr_i[i]);
                end
            end

            // Pick the flag shown by the trigger code
            always_comb begin
                case (code)
                    TRIG_FALL: vis_o[i] = fall_flag_q;
                    TRIG_RISE: vis_o[i] = rise_flag_q;
                    default:   vis_o[i] = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_regfile.sv
// Register file: direction, output value and trigger configuration
// storage, status clear decode and the read multiplexer.
// Assumes NUM_LINES <= DATA_W and 2*NUM_IN <= DATA_W.
module gpio_regfile
    import edge_gpio_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int NUM_IN    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [NUM_LINES-1:0] pin_lvl_i,
    input  logic [NUM_IN-1:0]    vis_i,
    output logic [NUM_LINES-1:0] dir_q_o,
    output logic [NUM_LINES-1:0] out_q_o,
    output logic [2*NUM_IN-1:0]  cfg_q_o,
    output logic [NUM_IN-1:0]    clr_o,
    output logic [DATA_W-1:0]    rdata_o
);
    // Store direction, output and configuration bytes on writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q_o <= '0;
            out_q_o <= '0;
            cfg_q_o <= '0;
        end else if (wr_en_i) begin
            case (addr_i)
                OFF_DIR:  dir_q_o <= wdata_i[NUM_LINES-1:0];
                OFF_DATA: out_q_o <= wdata_i[NUM_LINES-1:0];
                OFF_TRIG: cfg_q_o <= wdata_i[2*NUM_IN-1:0];
                default:  ;
            endcase
        end
    end

    // Decode the write-one-to-clear status access
    always_comb begin
        clr_o = '0;
        if (wr_en_i && addr_i == OFF_STAT) clr_o = wdata_i[NUM_IN-1:0];
    end

    // Select read data; unmapped offsets return zero
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFF_DIR:  rdata_o[NUM_LINES-1:0] = dir_q_o;
            OFF_DATA: rdata_o[NUM_LINES-1:0] = pin_lvl_i;
            OFF_TRIG: rdata_o[2*NUM_IN-1:0]  = cfg_q_o;
            OFF_STAT: rdata_o[NUM_IN-1:0]    = vis_i;
            default:  ;
        endcase
    end
endmodule

// File: rtl/edge_gpio_ctrl.sv
// Top of the edge-interrupt GPIO controller. Lines below NUM_OUT are
// outputs, the rest are interrupt-capable inputs. Pins pass through a
// synchroniser, the inputs feed the edge-flag store, and the interrupt
// is the OR of the visible status bits.
// Assumes NUM_OUT + NUM_IN <= 8 and 2*NUM_IN <= 8 (byte registers).
module edge_gpio_ctrl
    import edge_gpio_ctrl_pkg::*;
#(
    parameter int NUM_OUT     = 4,
    parameter int NUM_IN      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    input  logic [NUM_OUT+NUM_IN-1:0] pins_i,
    output logic [NUM_OUT+NUM_IN-1:0] dir_o,
    output logic [NUM_OUT+NUM_IN-1:0] out_o,
    output logic                 irq_o
);
    localparam int NUM_LINES = NUM_OUT + NUM_IN;

    logic [NUM_LINES-1:0] pin_lvl;
    logic [2*NUM_IN-1:0]  cfg_q;
    logic [NUM_IN-1:0]    clr;
    logic [NUM_IN-1:0]    vis;

    gpio_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (pin_lvl)
    );

    gpio_edge_flags #(
        .NUM_IN (NUM_IN)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (pin_lvl[NUM_LINES-1:NUM_OUT]),
        .cfg_i (cfg_q),
        .clr_i (clr),
        .vis_o (vis)
    );

    gpio_regfile #(
        .NUM_LINES (NUM_LINES),
        .NUM_IN    (NUM_IN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wdata_i   (wdata_i),
        .pin_lvl_i (pin_lvl),
        .vis_i     (vis),
        .dir_q_o   (dir_o),
        .out_q_o   (out_o),
        .cfg_q_o   (cfg_q),
        .clr_o     (clr),
        .rdata_o   (rdata_o)
    );

    // Interrupt request follows any visible pending flag
    assign irq_o = |vis;
endmodule

// File: rtl/edge_gpio_ctrl_chk.sv
// Port-level property checker for edge_gpio_ctrl, attached by bind.
module edge_gpio_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr_i,
    input logic       wr_en_i,
    input logic [7:0] wdata_i,
    input logic [7:0] rdata_o,
    input logic [7:0] dir_o,
    input logic [7:0] out_o,
    input logic       irq_o
);
    // R9
    irq_status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 3'd4) |-> (irq_o == (rdata_o != 8'd0)));

    // R10
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 3'd2 || addr_i > 3'd4) |-> (rdata_o == 8'd0));

    // R10
    unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (addr_i == 3'd2 || addr_i > 3'd4)) |=> ($stable(dir_o) && $stable(out_o)));

    // R1
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 3'd0) |=> (dir_o == $past(wdata_i)));

    // R2
    out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 3'd1) |=> (out_o == $past(wdata_i)));

    // R6
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 3'd4) |-> (rdata_o[7:4] == 4'd0));

    // R11
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (dir_o == 8'd0 && out_o == 8'd0 && !irq_o));
endmodule

bind edge_gpio_ctrl edge_gpio_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .dir_o   (dir_o),
    .out_o   (out_o),
    .irq_o   (irq_o)
);

// File: tb/edge_gpio_ctrl_bench.sv
module edge_gpio_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pins = '0;
    logic [7:0] dir;
    logic [7:0] outv;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Cycle model state
    logic [7:0] m_s1, m_s2, m_s3, m_dir, m_out, m_cfg;
    logic [3:0] m_rf, m_ff;

    always #5 clk = ~clk;

    edge_gpio_ctrl u_edge_gpio_ctrl (
        .clk (clk), .rst_n (rst_n), .addr_i (addr), .wr_en_i (wr_en),
        .wdata_i (wdata), .rdata_o (rdata), .pins_i (pins),
        .dir_o (dir), .out_o (outv), .irq_o (irq)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
        end
    endtask

    function automatic logic [3:0] m_vis();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) begin
            case (m_cfg[2*i +: 2])
                2'b01:   v[i] = m_ff[i];
                2'b10:   v[i] = m_rf[i];
                default: v[i] = 1'b0;
            endcase
        end
        return v;
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_dir;
            3'd1:    return m_s2;
            3'd3:    return m_cfg;
            3'd4:    return {4'd0, m_vis()};
            default: return 8'd0;
        endcase
    endfunction

    task automatic m_reset();
        m_s1 = '0; m_s2 = '0; m_s3 = '0;
        m_dir = '0; m_out = '0; m_cfg = '0; m_rf = '0; m_ff = '0;
    endtask

    // Advance the model across one rising edge using pre-edge inputs
    task automatic m_step(input logic [2:0] a, input logic w, input logic [7:0] d, input logic [7:0] p);
        logic [3:0] rise, fall, clr;
        rise = m_s2[7:4] & ~m_s3[7:4];
        fall = ~m_s2[7:4] & m_s3[7:4];
        clr  = (w && a == 3'd4) ? d[3:0] : 4'd0;
        m_rf = rise | (m_rf & ~clr);
        m_ff = fall | (m_ff & ~clr);
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = p;
        if (w) begin
            if (a == 3'd0) m_dir = d;
            if (a == 3'd1) m_out = d;
            if (a == 3'd3) m_cfg = d;
        end
    endtask

    // One bus cycle: drive at negedge, model at posedge, compare at negedge
    task automatic cyc(input string tag, input logic [2:0] a, input logic w, input logic [7:0] d, input logic [7:0] p);
        addr = a; wr_en = w; wdata = d; pins = p;
        @(posedge clk);
        m_step(a, w, d, p);
        @(negedge clk);
        wr_en = 1'b0;
        chk(tag, "rdata", rdata, m_read(a));
        chk(tag, "irq", {7'd0, irq}, {7'd0, (m_vis() != 4'd0)});
        chk(tag, "dir", dir, m_dir);
        chk(tag, "out", outv, m_out);
    endtask

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd3:    return "R3";
            3'd4:    return "R7";
            default: return "R10";
        endcase
    endfunction

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] p;
        void'($urandom(32'd4242));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: all registers and flags clear after reset
        chk("R11", "dir", dir, 8'h00);
        chk("R11", "out", outv, 8'h00);
        chk("R11", "irq", {7'd0, irq}, 8'h00);
        cyc("R11", 3'd3, 0, 0, 0);
        chk("R11", "cfg", rdata, 8'h00);
        cyc("R11", 3'd4, 0, 0, 0);
        chk("R11", "status", rdata, 8'h00);

        // R1: direction register
        cyc("R1", 3'd0, 1, 8'h0F, 0);
        cyc("R1", 3'd0, 0, 0, 0);
        chk("R1", "dir readback", rdata, 8'h0F);

        // R2: output write and synchronised pin read
        cyc("R2", 3'd1, 1, 8'hA5, 8'h3C);
        chk("R2", "out_o", outv, 8'hA5);
        cyc("R2", 3'd1, 0, 0, 8'h3C);
        chk("R2", "pin read", rdata, 8'h3C);
        cyc("R2", 3'd1, 0, 0, 8'h0C);
        cyc("R2", 3'd1, 0, 0, 8'h0C);
        chk("R2", "pins 4-7 fall read", rdata, 8'h0C);

        // R5: flags latched while unselected (lines 4,5 fell above)
        cyc("R5", 3'd4, 0, 0, 8'h0C);
        chk("R4", "none hides", rdata, 8'h00);
        cyc("R3", 3'd3, 1, 8'h05, 8'h0C);
        cyc("R3", 3'd4, 0, 0, 8'h0C);
        chk("R3", "falling shown", rdata, 8'h03);
        chk("R9", "irq", {7'd0, irq}, 8'h01);
        cyc("R3", 3'd3, 1, 8'h0A, 8'h0C);
        cyc("R3", 3'd4, 0, 0, 8'h0C);
        chk("R5", "rising of lines 4,5", rdata, 8'h03);
        cyc("R4", 3'd3, 1, 8'hFF, 8'h0C);
        cyc("R4", 3'd4, 0, 0, 8'h0C);
        chk("R4", "code 11 hides", rdata, 8'h00);
        chk("R4", "irq", {7'd0, irq}, 8'h00);

        // R7: clear input 0 only, both flags
        cyc("R7", 3'd4, 1, 8'h01, 8'h0C);
        cyc("R7", 3'd3, 1, 8'h0A, 8'h0C);
        cyc("R7", 3'd4, 0, 0, 8'h0C);
        chk("R7", "rise cleared on 0 only", rdata, 8'h02);
        cyc("R7", 3'd3, 1, 8'h05, 8'h0C);
        cyc("R7", 3'd4, 0, 0, 8'h0C);
        chk("R7", "fall cleared on 0 only", rdata, 8'h02);

        // R5: lines 0-3 toggling never flag
        cyc("R5", 3'd4, 1, 8'h0F, 8'h03);
        cyc("R5", 3'd3, 1, 8'hAA, 8'h00);
        cyc("R5", 3'd4, 0, 0, 8'h0F);
        cyc("R5", 3'd4, 0, 0, 8'h0F);
        cyc("R5", 3'd4, 0, 0, 8'h0F);
        chk("R5", "low lines no flag", rdata, 8'h00);

        // R8: clear meets a new rising edge on line 5
        cyc("R8", 3'd4, 0, 0, 8'h20);
        cyc("R8", 3'd4, 0, 0, 8'h20);
        cyc("R8", 3'd4, 1, 8'h02, 8'h20);
        chk("R8", "edge wins", rdata, 8'h02);
        chk("R8", "irq", {7'd0, irq}, 8'h01);

        // R10: unmapped offsets
        cyc("R10", 3'd2, 1, 8'hFF, 8'h20);
        cyc("R10", 3'd5, 1, 8'hFF, 8'h20);
        cyc("R10", 3'd6, 1, 8'hFF, 8'h20);
        cyc("R10", 3'd7, 1, 8'hFF, 8'h20);
        chk("R10", "read zero", rdata, 8'h00);
        cyc("R10", 3'd0, 0, 0, 8'h20);
        chk("R10", "dir kept", rdata, 8'h0F);
        cyc("R10", 3'd3, 0, 0, 8'h20);
        chk("R10", "cfg kept", rdata, 8'hAA);

        // R6/R9: random traffic against the model
        p = 8'h20;
        for (int n = 0; n < 5000; n++) begin
            logic [2:0] a;
            logic       w;
            logic [7:0] d;
            if ($urandom_range(5) == 0) p[$urandom_range(7)] ^= 1'b1;
            a = 3'($urandom_range(7));
            w = ($urandom_range(2) == 0);
            d = 8'($urandom);
            cyc((a == 3'd4 && !w) ? "R6" : tag_of(a), a, w, d, p);
        end
        for (int n = 0; n < 200; n++) begin
            if ($urandom_range(3) == 0) p[7:4] ^= 4'($urandom);
            cyc("R9", 3'd4, 0, 0, p);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule